// File: doc/BRIEF.md
# Clocked Synchronous Serial Transmitter with FIFO

This block sends bytes as a clocked synchronous serial stream. Bytes enter a 16-entry transmit FIFO through a valid/ready write port. The shift stage takes the oldest entry and sends its eight bits least significant bit first, one bit per clock pulse. A new bit is driven on each falling edge of the serial clock, so a receiver can sample it on the rising edge. A mode input selects the clock source. In internal mode the block divides the system clock, drives the serial clock out and makes each phase last `divider + 1` system clocks. In external mode the incoming serial clock passes through a two-flop synchronizer and an edge detector, and the data follows its edges.

The FIFO is checked when the last bit of a frame ends. If a byte is waiting, it is loaded at that moment and the next frame starts after exactly one half-period, with no idle gap. If the FIFO is empty, the block raises a transmit-end flag. The serial clock then rests high and the data line keeps the level of the last bit sent. A FIFO-empty flag tracks a programmable threshold and drives an interrupt output through an enable.

Back-pressure on the write port: a byte is accepted only in a cycle where both `wr_valid` and `wr_ready` are high. `wr_ready` is low while the FIFO holds 16 entries or while `fifo_clr` is high. A byte offered while `wr_ready` is low is not stored.

Top module: `cstx_top`

## Requirements
- R1: In internal mode, `sck_out` rests high and produces exactly eight low pulses per frame. Every low phase and every high phase lasts `divider + 1` clock cycles.
- R2: `txd` changes only when `sck_out` falls. The bits of a byte appear bit 0 first and bit 7 last, so sampling on the rising edges rebuilds the byte.
- R3: If the FIFO holds a byte when the last rising edge of a frame occurs, the next frame's first falling edge follows one half-period later. No extra idle time is inserted.
- R4: `tend` is set once the last bit's rising edge passes with an empty FIFO. `tend` is cleared by an accepted write or by the start of a frame, and a clear in the same cycle as a set wins.
- R5: While idle after transmission, `sck_out` is 1 and `txd` holds bit 7 of the last byte sent.
- R6: `tdfe` becomes 1 in the cycle after `fifo_count <= thresh`. A pulse on `empty_clr` clears `tdfe` only while `fifo_count > thresh`.
- R7: `irq` is 1 exactly when `tdfe` and `int_en` are both 1.
- R8: `wr_ready` is 0 when `fifo_count` is 16 or `fifo_clr` is 1. A byte offered while `wr_ready` is 0 changes neither the count nor the data sent.
- R9: A `fifo_clr` pulse sets `fifo_count` to 0 in the next cycle. A frame already in progress finishes.
- R10: In external mode (`ext_mode` = 1), `sck_out` stays 1. Each falling edge of `ext_sck` drives the next bit on `txd` three clock cycles after the edge, measured through the synchronizer.
- R11: After reset, `txd` = 1, `sck_out` = 1, `tend` = 1, `tdfe` = 1 and `fifo_count` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_clr | input | 1 | Empties the transmit FIFO |
| ext_mode | input | 1 | 1 selects the external serial clock, 0 the internal divider |
| divider | input | DIV_W | Internal half-period minus one, in clock cycles |
| ext_sck | input | 1 | External serial clock (asynchronous) |
| thresh | input | CNT_W | FIFO-empty threshold |
| int_en | input | 1 | Interrupt enable |
| empty_clr | input | 1 | Clear strobe for `tdfe` |
| wr_valid | input | 1 | Write data valid |
| wr_data | input | 8 | Byte to enqueue |
| wr_ready | output | 1 | FIFO can accept a byte |
| txd | output | 1 | Serial data out |
| sck_out | output | 1 | Serial clock out, idle high |
| tend | output | 1 | Transmission ended flag |
| tdfe | output | 1 | FIFO at or below threshold flag |
| irq | output | 1 | Transmit interrupt request |
| fifo_count | output | CNT_W | Entries held in the FIFO |

## Verification
The properties assume that `ext_mode` changes only while the block is idle. They also assume that `ext_sck` alternates slowly enough for each synchronized edge to be seen on its own, and that `thresh` and `divider` stay fixed during a frame. The stimulus switches mode only after `tend` is seen high. It drives the external clock with phases of four system clocks, well above the synchronizer latency, and it sets `divider` and `thresh` only between bursts.

// File: rtl/cstx_pkg.sv
package cstx_pkg;
  localparam int FRAME_BITS = 8;
  localparam int BIT_W = $clog2(FRAME_BITS + 1);

  typedef logic [FRAME_BITS-1:0] byte_t;

  typedef struct packed {
    logic fall;
    logic rise;
  } sck_ev_t;
endpackage

// File: rtl/cstx_fifo.sv
module cstx_fifo #(
  parameter int DEPTH = 16,
  parameter int W = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     dout,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);
  assign dout  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push && !clr) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/cstx_sckgen.sv
module cstx_sckgen
  import cstx_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_mode,
  input  logic             ext_sck,
  input  logic             run,
  input  logic             low_phase,
  input  logic [DIV_W-1:0] divider,
  output sck_ev_t          ev
);
  logic [SYNC_N:0]  sy;
  logic [DIV_W-1:0] divcnt;
  logic             int_tick, ext_fall, ext_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sy <= '1;
    else        sy <= {sy[SYNC_N-1:0], ext_sck};
  end

  assign ext_fall = ext_mode &&  sy[SYNC_N] && !sy[SYNC_N-1];
  assign ext_rise = ext_mode && !sy[SYNC_N] &&  sy[SYNC_N-1];
  assign int_tick = run && !ext_mode && (divcnt == divider);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                divcnt <= '0;
    else if (run && !ext_mode) divcnt <= (divcnt == divider) ? '0 : divcnt + 1'b1;
    else                       divcnt <= '0;
  end

  assign ev.fall = run && !low_phase && (int_tick || ext_fall);
  assign ev.rise = run &&  low_phase && (int_tick || ext_rise);
endmodule

// File: rtl/cstx_shifter.sv
module cstx_shifter
  import cstx_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  sck_ev_t ev,
  input  logic    have_data,
  input  byte_t   head,
  input  logic    wr_acc,
  output logic    pop,
  output logic    busy,
  output logic    low_phase,
  output logic    txd,
  output logic    tend
);
  logic [BIT_W-1:0] bitn;
  byte_t            sh;
  logic             start, last, reload, finish;

  assign start  = !busy && have_data;
  assign last   = ev.rise && (bitn == BIT_W'(FRAME_BITS));
  assign reload = last && have_data;
  assign finish = last && !have_data;
  assign pop    = start || reload;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      low_phase <= 1'b0;
      txd       <= 1'b1;
      tend      <= 1'b1;
      sh        <= '0;
      bitn      <= '0;
    end else begin
      if (wr_acc || start) tend <= 1'b0;
      else if (finish)     tend <= 1'b1;

      if (start) begin
        busy      <= 1'b1;
        sh        <= head;
        bitn      <= '0;
        low_phase <= 1'b0;
      end
      if (ev.fall) begin
        txd       <= sh[0];
        sh        <= sh >> 1;
        bitn      <= bitn + 1'b1;
        low_phase <= 1'b1;
      end
      if (ev.rise) begin
        low_phase <= 1'b0;
        if (reload) begin
          sh   <= head;
          bitn <= '0;
        end
        if (finish) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cstx_top.sv
module cstx_top
  import cstx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DIV_W = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_clr,
  input  logic             ext_mode,
  input  logic [DIV_W-1:0] divider,
  input  logic             ext_sck,
  input  logic [CNT_W-1:0] thresh,
  input  logic             int_en,
  input  logic             empty_clr,
  input  logic             wr_valid,
  input  logic [7:0]       wr_data,
  output logic             wr_ready,
  output logic             txd,
  output logic             sck_out,
  output logic             tend,
  output logic             tdfe,
  output logic             irq,
  output logic [CNT_W-1:0] fifo_count
);
  logic    full, empty, push, pop, busy, low_phase, have_data;
  byte_t   head;
  sck_ev_t ev;

  assign wr_ready  = !full && !fifo_clr;
  assign push      = wr_valid && wr_ready;
  assign have_data = !empty && !fifo_clr;

  cstx_fifo #(.DEPTH(DEPTH), .W(FRAME_BITS)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clr(fifo_clr), .push(push), .din(wr_data),
    .pop(pop), .dout(head), .count(fifo_count), .full(full), .empty(empty)
  );

  cstx_sckgen #(.DIV_W(DIV_W), .SYNC_N(2)) u_sckgen (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .ext_sck(ext_sck),
    .run(busy), .low_phase(low_phase), .divider(divider), .ev(ev)
  );

  cstx_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .ev(ev), .have_data(have_data), .head(head),
    .wr_acc(push), .pop(pop), .busy(busy), .low_phase(low_phase),
    .txd(txd), .tend(tend)
  );

  assign sck_out = ext_mode ? 1'b1 : !low_phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   tdfe <= 1'b1;
    else if (fifo_count <= thresh) tdfe <= 1'b1;
    else if (empty_clr)           tdfe <= 1'b0;
  end

  assign irq = tdfe && int_en;
endmodule

// File: rtl/cstx_checker.sv
module cstx_checker #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ext_mode,
  input logic             fifo_clr,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic             txd,
  input logic             sck_out,
  input logic             tend,
  input logic             tdfe,
  input logic [CNT_W-1:0] thresh,
  input logic [CNT_W-1:0] fifo_count
);
  a_r2_txd_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_mode && !$stable(txd)) |-> !sck_out);

  a_r4_write_clears_tend: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> !tend);

  a_r5_idle_clock_high: assert property (@(posedge clk) disable iff (!rst_n)
    tend |-> sck_out);

  a_r6_threshold_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_count <= thresh) |=> tdfe);

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_count <= CNT_W'(DEPTH));

  a_r8_full_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_count == CNT_W'(DEPTH)) |-> !wr_ready);

  a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> (fifo_count == '0));

  a_r10_ext_clock_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ext_mode |-> sck_out);
endmodule

bind cstx_top cstx_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_cstx_chk (
  .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .fifo_clr(fifo_clr),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .txd(txd), .sck_out(sck_out),
  .tend(tend), .tdfe(tdfe), .thresh(thresh), .fifo_count(fifo_count)
);

// File: tb/test_cstx_top.sv
`timescale 1ns/1ps
module test_cstx_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fifo_clr = 1'b0, ext_mode = 1'b0, ext_sck = 1'b1;
  logic [7:0] divider = 8'd2;
  logic [4:0] thresh = 5'd4;
  logic       int_en = 1'b1, empty_clr = 1'b0, wr_valid = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       wr_ready, txd, sck_out, tend, tdfe, irq;
  logic [4:0] fifo_count;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cstx_top i_cstx_top (
    .clk(clk), .rst_n(rst_n), .fifo_clr(fifo_clr), .ext_mode(ext_mode),
    .divider(divider), .ext_sck(ext_sck), .thresh(thresh), .int_en(int_en),
    .empty_clr(empty_clr), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .txd(txd), .sck_out(sck_out), .tend(tend),
    .tdfe(tdfe), .irq(irq), .fifo_count(fifo_count)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0] q[$];
  int m_busy, m_low, m_bitn, m_div, m_txd, m_tend, m_tdfe, s1, s2, sp;
  logic [7:0] m_sh;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      q.delete();
      m_busy = 0; m_low = 0; m_bitn = 0; m_div = 0; m_txd = 1; m_tend = 1;
      m_tdfe = 1; s1 = 1; s2 = 1; sp = 1; m_sh = 8'h00;
    end else begin
      int cnt, ne, tick, ef, er, fall, rise, start, fin8, reload, finish, push;
      cnt    = q.size();
      ne     = (cnt > 0) && !fifo_clr;
      tick   = m_busy && !ext_mode && (m_div == int'(divider));
      ef     = ext_mode && sp && !s2;
      er     = ext_mode && !sp && s2;
      fall   = m_busy && !m_low && (tick || ef);
      rise   = m_busy && m_low && (tick || er);
      start  = !m_busy && ne;
      fin8   = rise && (m_bitn == 8);
      reload = fin8 && ne;
      finish = fin8 && !ne;
      push   = wr_valid && (cnt < 16) && !fifo_clr;
      if (cnt <= int'(thresh)) m_tdfe = 1;
      else if (empty_clr)      m_tdfe = 0;
      if (push || start) m_tend = 0;
      else if (finish)   m_tend = 1;
      m_div = (m_busy && !ext_mode) ? ((m_div == int'(divider)) ? 0 : m_div + 1) : 0;
      sp = s2; s2 = s1; s1 = ext_sck;
      if (start) begin m_sh = q[0]; m_busy = 1; m_bitn = 0; m_low = 0; end
      if (fall) begin m_txd = m_sh[0]; m_sh = m_sh >> 1; m_bitn++; m_low = 1; end
      if (rise) begin
        m_low = 0;
        if (reload) begin m_sh = q[0]; m_bitn = 0; end
        if (finish) m_busy = 0;
      end
      if (fifo_clr) q.delete();
      else begin
        if (start || reload) void'(q.pop_front());
        if (push) q.push_back(wr_data);
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R2 txd", txd, m_txd);
      check("R1/R10 sck_out", sck_out, ext_mode ? 1 : !m_low);
      check("R4 tend", tend, m_tend);
      check("R6 tdfe", tdfe, m_tdfe);
      check("R7 irq", irq, m_tdfe && int_en);
      check("R8 wr_ready", wr_ready, (q.size() < 16) && !fifo_clr);
      check("R9 fifo_count", fifo_count, q.size());
    end
  end

  // ---------------- independent receiver and clock timing monitor ----------------
  logic [7:0] rx_q[$];
  logic [7:0] rx_sh;
  int rx_n = 0, prev_line = 1, falls = 0, last_edge = -1, mon_on = 0;
  always @(negedge clk) begin
    int line;
    line = ext_mode ? int'(ext_sck) : int'(sck_out);
    if (rst_n && mon_on) begin
      if (line != prev_line && !ext_mode) begin
        if (last_edge >= 0)
          check("R1/R3 half-period", cyc - last_edge, int'(divider) + 1);
        last_edge = cyc;
      end
      if (line == 0 && prev_line == 1) falls++;
      if (line == 1 && prev_line == 0) begin
        rx_sh = {txd, rx_sh[7:1]};
        rx_n++;
        if (rx_n == 8) begin rx_q.push_back(rx_sh); rx_n = 0; end
      end
    end
    prev_line = line;
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    if (cyc > 100000 && !done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=<100000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive_write(input logic [7:0] d);
    @(negedge clk); #2;
    wr_valid = 1'b1; wr_data = d;
    @(negedge clk); #2;
    wr_valid = 1'b0;
  endtask

  task automatic wait_tend;
    int lim = 0;
    @(negedge clk);
    while (!tend && lim < 5000) begin @(negedge clk); lim++; end
  endtask

  logic [7:0] sent[$];

  initial begin
    tick(3); #2 rst_n = 1'b1;
    @(negedge clk);
    // R11: reset state
    check("R11 txd", txd, 1);
    check("R11 sck_out", sck_out, 1);
    check("R11 tend", tend, 1);
    check("R11 tdfe", tdfe, 1);
    check("R11 fifo_count", fifo_count, 0);

    // internal mode burst: R1, R2, R3, R5
    mon_on = 1; falls = 0; rx_q.delete(); rx_n = 0; last_edge = -1;
    sent = '{8'hA5, 8'h3C, 8'h41};
    @(negedge clk); #2;
    foreach (sent[i]) begin
      wr_valid = 1'b1; wr_data = sent[i];
      @(negedge clk); #2;
    end
    wr_valid = 1'b0;
    wait_tend();
    tick(4);
    mon_on = 0;
    check("R1 falls per 3 frames", falls, 24);
    check("R2 bytes received", rx_q.size(), 3);
    foreach (sent[i]) if (i < rx_q.size()) check("R2 byte order", rx_q[i], sent[i]);
    check("R5 txd holds bit7", txd, 0);
    check("R5 sck idle high", sck_out, 1);
    check("R4 tend after burst", tend, 1);

    // fill FIFO past capacity: R8, R6, R9, R4
    divider = 8'd20;
    @(negedge clk); #2;
    for (int i = 0; i < 22; i++) begin
      wr_valid = 1'b1; wr_data = 8'(i + 8'h10);
      @(negedge clk); #2;
    end
    check("R4 tend cleared by write", tend, 0);
    check("R8 count full", fifo_count, 16);
    check("R8 not ready when full", wr_ready, 0);
    tick(3);
    check("R8 ignored write keeps count", fifo_count, 16);
    wr_valid = 1'b0;
    empty_clr = 1'b1; @(negedge clk); #2; empty_clr = 1'b0;
    check("R6 clear above threshold", tdfe, 0);
    check("R7 irq follows", irq, 0);
    fifo_clr = 1'b1; @(negedge clk); #2; fifo_clr = 1'b0;
    check("R9 cleared", fifo_count, 0);
    @(negedge clk);
    check("R6 set at threshold", tdfe, 1);
    empty_clr = 1'b1; @(negedge clk); #2; empty_clr = 1'b0;
    @(negedge clk);
    check("R6 clear ignored at threshold", tdfe, 1);
    int_en = 1'b0; @(negedge clk);
    check("R7 irq masked", irq, 0);
    int_en = 1'b1; @(negedge clk);
    check("R7 irq enabled", irq, 1);
    wait_tend();
    check("R9 frame in flight completes", tend, 1);

    // external mode: R10
    tick(2); #2;
    ext_mode = 1'b1;
    tick(4);
    mon_on = 1; rx_q.delete(); rx_n = 0; prev_line = 1;
    sent = '{8'h96, 8'h5A};
    drive_write(8'h96);
    drive_write(8'h5A);
    tick(4); #2;
    for (int p = 0; p < 16; p++) begin
      ext_sck = 1'b0; tick(4); #2;
      ext_sck = 1'b1; tick(4); #2;
      check("R10 sck_out held high", sck_out, 1);
    end
    tick(8);
    mon_on = 0;
    check("R10 bytes received", rx_q.size(), 2);
    foreach (sent[i]) if (i < rx_q.size()) check("R10 ext byte", rx_q[i], sent[i]);
    check("R4 tend after ext frames", tend, 1);
    check("R5 txd holds bit7 ext", txd, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule